// File: doc/BRIEF.md
# I2C Clock-Low Timeout Monitor

This block sits beside an I2C master and guards against a slave that stretches SCL indefinitely during a transfer. Once the master signals that a START has gone out, a 12-bit down-counter is armed from an 8-bit software value. The hardware appends four zero bits below that value. The counter steps down on a free-running bit-rate tick, and that tick keeps running while the slave holds the clock low. Whenever the synchronized SCL is seen high, the counter reloads, so only one unbroken low stretch can use up the budget.

When the budget runs out, the block sets a sticky interrupt flag and a timeout status bit. It also asks the master state machine to abort with a STOP. A separate qualifier tells the master that the STOP may be driven now, which is only true once both lines have been let go. Raw SDA and SCL, after a two-flop synchronizer, are brought out so that software can judge the state of the slave. All pins are plain control and status signals. There is no streamed data path, so no valid/ready handshake applies.

Top module: `scl_lowto_mon`

## Requirements
- R1: The reload value is the 8-bit programmed count followed by four zero bits. With SCL held low, the timeout fires on exactly the (count×16)-th tick after the load. For example, 0x02 fires on tick 32 and 0xDA fires on tick 3488, not one tick earlier.
- R2: A programmed count of 0x00 or 0x01 disables the timeout. No flag is raised however many ticks pass.
- R3: The counter is loaded when the START strobe arrives. While the bus is idle (after reset or after the STOP-sent strobe, and before the next START) ticks cause no timeout.
- R4: The counter moves only in cycles where `bit_tick` is 1. Clock cycles without a tick do not advance it, even while SCL is low.
- R5: Any cycle in which the synchronized SCL is high reloads the counter from the programmed value, so the budget restarts after every release.
- R6: One cycle after the terminal tick, `raw_irq`, `to_status` and `force_stop_req` are all 1.
- R7: `stop_go` is 1 only while `force_stop_req` is 1 and the synchronized SCL and SDA are both 1.
- R8: The STOP-sent strobe clears `to_status` and `force_stop_req`. An active-low reset clears every flag.
- R9: `raw_irq` stays at 1 until a cycle with `irq_clr` equal to 1, and the STOP-sent strobe does not clear it. `irq` equals `raw_irq` AND `irq_en`.
- R10: `mon_scl` and `mon_sda` follow `scl_in` and `sda_in` after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, also the master reset |
| cfg_wr | input | 1 | Write strobe for the programmed count |
| cfg_data | input | 8 | Programmed count (upper 8 of 12 counter bits) |
| bit_tick | input | 1 | One-cycle pulse per internal bit-clock falling edge |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| start_det | input | 1 | START condition detected strobe |
| stop_sent | input | 1 | STOP condition sent strobe |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-1 clear of the raw interrupt flag |
| raw_irq | output | 1 | Sticky raw timeout interrupt flag |
| irq | output | 1 | Masked interrupt |
| to_status | output | 1 | Timeout status bit |
| force_stop_req | output | 1 | Request to the master to abort with STOP |
| stop_go | output | 1 | Forced STOP may be driven now |
| mon_scl | output | 1 | Synchronized SCL level |
| mon_sda | output | 1 | Synchronized SDA level |

## Verification
The bench builds the block with its defaults: an 8-bit programmed field, a 4-bit zero extension and a two-stage synchronizer. Because the bench drives the tick on every cycle, the largest case (0xDA, 3488 ticks) completes in a few thousand cycles. This lets the scaling be checked exactly at tick 3487 and at tick 3488. The small values 0x02 and 0x03 bring the off-by-one edges, the reload on SCL release and the gap-without-tick case within a few dozen cycles each.

// File: rtl/lto_pkg.sv
package lto_pkg;
  localparam int CFG_W_DEF  = 8;
  localparam int ZERO_W_DEF = 4;
  localparam int SYNC_DEF   = 2;

  typedef struct packed {
    logic raw;
    logic status;
    logic abort;
  } lto_flags_t;
endpackage

// File: rtl/lto_sync.sv
module lto_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_in,
  output logic [LINES-1:0] d_out
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_in[g]};
    end
    assign d_out[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/lto_counter.sv
module lto_counter #(
  parameter int CFG_W  = 8,
  parameter int ZERO_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_q,
  input  logic             start_det,
  input  logic             stop_sent,
  input  logic             bit_tick,
  input  logic             scl_s,
  output logic             expire
);
  localparam int CNT_W = CFG_W + ZERO_W;

  logic             active;
  logic             enabled;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;
  logic             step;

  assign enabled = (cfg_q > CFG_W'(1));
  assign reload  = {cfg_q, {ZERO_W{1'b0}}};
  assign step    = active && !start_det && !scl_s && bit_tick && enabled && (cnt != '0);
  assign expire  = step && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active <= 1'b0;
    else if (start_det) active <= 1'b1;
    else if (stop_sent) active <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (start_det)        cnt <= reload;
    else if (active && scl_s)  cnt <= reload;
    else if (step)             cnt <= cnt - CNT_W'(1);
  end

  // R2: a disabled count never expires
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !expire);
  // R3: idle bus keeps the counter frozen
  p_idle_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start_det) |=> $stable(cnt));
  // R4: no tick, no movement while low
  p_tick_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start_det && !scl_s && !bit_tick) |=> $stable(cnt));
  // R5: released clock restores the budget
  p_release_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && scl_s && !start_det) |=> (cnt == {$past(cfg_q), {ZERO_W{1'b0}}}));
endmodule

// File: rtl/lto_status.sv
module lto_status
  import lto_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic stop_sent,
  input  logic irq_clr,
  input  logic irq_en,
  output logic raw_irq,
  output logic irq,
  output logic to_status,
  output logic force_stop_req
);
  lto_flags_t fl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl <= '0;
    end else begin
      if (expire)        fl.raw <= 1'b1;
      else if (irq_clr)  fl.raw <= 1'b0;
      if (expire)         begin fl.status <= 1'b1; fl.abort <= 1'b1; end
      else if (stop_sent) begin fl.status <= 1'b0; fl.abort <= 1'b0; end
    end
  end

  assign raw_irq        = fl.raw;
  assign to_status      = fl.status;
  assign force_stop_req = fl.abort;
  assign irq            = fl.raw & irq_en;

  // R6: terminal tick raises all three flags
  p_flags_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (raw_irq && to_status && force_stop_req));
  // R8: STOP sent drops status and abort request
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_sent && !expire) |=> (!to_status && !force_stop_req));
  // R9: raw flag holds unless cleared
  p_raw_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_irq && !irq_clr) |=> raw_irq);
endmodule

// File: rtl/scl_lowto_mon.sv
module scl_lowto_mon
  import lto_pkg::*;
#(
  parameter int CFG_W  = CFG_W_DEF,
  parameter int ZERO_W = ZERO_W_DEF,
  parameter int SYNC_N = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             bit_tick,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             start_det,
  input  logic             stop_sent,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             raw_irq,
  output logic             irq,
  output logic             to_status,
  output logic             force_stop_req,
  output logic             stop_go,
  output logic             mon_scl,
  output logic             mon_sda
);
  logic [CFG_W-1:0] cfg_q;
  logic [1:0]       lines_s;
  logic             expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_data;
  end

  lto_sync #(.LINES(2), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({sda_in, scl_in}), .d_out(lines_s));

  assign mon_scl = lines_s[0];
  assign mon_sda = lines_s[1];

  lto_counter #(.CFG_W(CFG_W), .ZERO_W(ZERO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .start_det(start_det),
    .stop_sent(stop_sent), .bit_tick(bit_tick), .scl_s(mon_scl), .expire(expire));

  lto_status u_stat (
    .clk(clk), .rst_n(rst_n), .expire(expire), .stop_sent(stop_sent),
    .irq_clr(irq_clr), .irq_en(irq_en), .raw_irq(raw_irq), .irq(irq),
    .to_status(to_status), .force_stop_req(force_stop_req));

  assign stop_go = force_stop_req & mon_scl & mon_sda;

  // R7: STOP released only onto a free bus
  p_stop_free_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_go |-> (force_stop_req && mon_scl && mon_sda));
  // R9: masked interrupt implies raw flag
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_irq && irq_en));
endmodule

// File: tb/sim_scl_lowto_mon.sv
module sim_scl_lowto_mon;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, cfg_wr = 0, bit_tick = 0, scl_in = 1, sda_in = 1;
  logic start_det = 0, stop_sent = 0, irq_en = 0, irq_clr = 0;
  logic [7:0] cfg_data = 0;
  logic raw_irq, irq, to_status, force_stop_req, stop_go, mon_scl, mon_sda;
  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  scl_lowto_mon u0 (.*);

  // {count, ticks, expected flag}
  localparam logic [7:0]  V_CFG [8] = '{8'h02, 8'h02, 8'h03, 8'h03, 8'h01, 8'h00, 8'h10, 8'h10};
  localparam int          V_TCK [8] = '{31, 32, 47, 48, 500, 100, 255, 256};
  localparam logic        V_EXP [8] = '{0, 1, 0, 1, 0, 0, 0, 1};

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_start(); start_det = 1; cyc(1); start_det = 0; endtask
  task automatic pulse_stop();  stop_sent = 1; cyc(1); stop_sent = 0; endtask
  task automatic pulse_clr();   irq_clr = 1;   cyc(1); irq_clr = 0;   endtask
  task automatic set_cfg(logic [7:0] v); cfg_data = v; cfg_wr = 1; cyc(1); cfg_wr = 0; endtask
  task automatic ticks(int n); if (n > 0) begin bit_tick = 1; cyc(n); bit_tick = 0; end endtask
  task automatic clean(); scl_in = 1; sda_in = 1; cyc(3); pulse_stop(); pulse_clr(); endtask
  task automatic arm_low(); scl_in = 0; cyc(3); pulse_start(); endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    cyc(2);
    chk("R8 reset raw_irq", raw_irq, 0);
    chk("R8 reset to_status", to_status, 0);
    chk("R8 reset force_stop_req", force_stop_req, 0);
    rst_n = 1; cyc(1);

    for (int i = 0; i < 8; i++) begin
      set_cfg(V_CFG[i]);
      arm_low();
      ticks(V_TCK[i]);
      chk($sformatf("R1 R2 vector %0d raw_irq", i), raw_irq, V_EXP[i]);
      clean();
    end

    // R3: idle ticks do nothing
    set_cfg(8'h02); scl_in = 0; cyc(3); ticks(100);
    chk("R3 idle no timeout", raw_irq, 0);
    arm_low(); ticks(20); pulse_stop(); ticks(50);
    chk("R3 after stop no timeout", raw_irq, 0);
    clean();

    // R4: gaps without tick do not count
    arm_low(); ticks(16); cyc(40); ticks(15);
    chk("R4 31 ticks with gap", raw_irq, 0);
    ticks(1);
    chk("R4 tick 32 fires", raw_irq, 1);
    clean();

    // R5: release reloads the budget
    arm_low(); ticks(20); scl_in = 1; cyc(4); scl_in = 0; cyc(3);
    ticks(31);
    chk("R5 31 after reload", raw_irq, 0);
    ticks(1);
    chk("R5 32 after reload", raw_irq, 1);
    chk("R6 to_status set", to_status, 1);
    chk("R6 force_stop_req set", force_stop_req, 1);
    // R7
    chk("R7 stop_go scl low", stop_go, 0);
    scl_in = 1; sda_in = 0; cyc(3);
    chk("R7 stop_go sda low", stop_go, 0);
    sda_in = 1; cyc(3);
    chk("R7 stop_go free bus", stop_go, 1);
    // R9 masking, R8 stop clear
    irq_en = 1; cyc(1);
    chk("R9 irq enabled", irq, 1);
    pulse_stop();
    chk("R8 stop clears status", to_status, 0);
    chk("R8 stop clears request", force_stop_req, 0);
    chk("R9 raw survives stop", raw_irq, 1);
    irq_en = 0; cyc(1);
    chk("R9 irq masked", irq, 0);
    pulse_clr();
    chk("R9 clear drops raw", raw_irq, 0);

    // R1 scaling 0xDA -> 3488
    set_cfg(8'hDA); arm_low(); ticks(3487);
    chk("R1 0xDA tick 3487", raw_irq, 0);
    ticks(1);
    chk("R1 0xDA tick 3488", raw_irq, 1);
    clean();

    // R10 monitor delay
    sda_in = 0; cyc(1);
    chk("R10 sda one edge", mon_sda, 1);
    cyc(1);
    chk("R10 sda two edges", mon_sda, 0);
    scl_in = 0; cyc(2);
    chk("R10 scl low", mon_scl, 0);

    // R8 reset clears flags
    set_cfg(8'h02); arm_low(); ticks(32);
    rst_n = 0; cyc(1);
    chk("R8 reset clears raw", raw_irq, 0);
    chk("R8 reset clears status", to_status, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule